// File: doc/BRIEF.md
# Aligned Clock-Enable Generator

This block runs entirely on one fast reference clock, nominally 2400 times a 32.768 kHz crystal (about 78.6 MHz). From that clock it produces single-cycle enable strobes for five consumers: a scaled master clock, a compute-engine clock, an ADC/filter clock, a processor clock and a 32 kHz tick. Downstream logic stays on the reference clock and qualifies its registers with these enables. No derived clock is gated or generated.

A free-running phase counter spans one tick period, which is 2400 reference cycles. Every rate divider restarts together at the tick boundary. As a result the ADC, compute-engine, processor and tick strobes all fire on the same reference cycle at the start of each window. Configuration inputs select the following:
- the master scaling ratio;
- a faster compute-engine rate, which has an effect only in the divide-by-2 ratio;
- an extra power-of-two slowdown for the processor;
- a brownout mode.

Configuration is sampled only at the tick boundary, so a change can never produce a runt or merged strobe. In brownout the fast strobes are silenced, and the ADC and processor run from a slow period of 2800 reference cycles (about 28 kHz).

Top module: `clk_en_gen`

## Requirements
- R1: While reset is high, every enable output is low. The first tick window after reset uses divide-by-4 with the processor slowdown at 0, the compute-engine rate bit at 0 and brownout off, whatever the configuration inputs are.
- R2: The ratio is selected by {ratio_fast_i, ratio_mid_i}. {1,0} gives divide-by-2, {0,1} gives divide-by-3, and {0,0} or {1,1} gives divide-by-4. The master enable pulses once every D reference cycles, so a window holds 2400/D master pulses.
- R3: The compute-engine enable period is 8·D cycles when D=2 and ce_fast_i=0, and 4·D cycles otherwise. ce_fast_i has no effect when D is 3 or 4.
- R4: The ADC enable pulses once every 4·D reference cycles.
- R5: The processor enable period is (4·D)·2^n cycles, where n is cpu_div_i (0 to 7). The period counter restarts at each tick boundary, so a window holds ceil(2400/period) pulses.
- R6: The tick enable pulses exactly once every TICK_DIV (2400) reference cycles in every mode, brownout included.
- R7: Outside brownout, the master, compute-engine, ADC and processor enables are all high on the cycle in which the tick enable is high.
- R8: The tick, compute-engine, ADC and processor enables are each high for exactly one reference cycle per pulse, never two cycles in a row.
- R9: A configuration change, brownout included, takes effect only from the next tick boundary. The window in progress completes with the old settings.
- R10: In brownout, the master and compute-engine enables stay low. The ADC and processor enables pulse once every SLOW_DIV (2800) cycles, starting on the first tick of brownout, and cpu_div_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_fast_i | input | 1 | Ratio select, upper bit |
| ratio_mid_i | input | 1 | Ratio select, lower bit |
| ce_fast_i | input | 1 | Faster compute-engine rate (divide-by-2 only) |
| cpu_div_i | input | 3 | Processor slowdown exponent n |
| brownout_i | input | 1 | Low-power brownout request |
| mck_en_o | output | 1 | Scaled master clock enable |
| ce_en_o | output | 1 | Compute-engine enable |
| adc_en_o | output | 1 | ADC/filter enable |
| cpu_en_o | output | 1 | Processor enable |
| tick_en_o | output | 1 | 32 kHz tick enable |

## Verification
The bench builds the block with its default TICK_DIV of 2400 and SLOW_DIV of 2800, and with the full 3-bit processor exponent. These values bring two corner cases within reach.

With an exponent of 7, the processor period of 2048 does not divide the window. This exposes the truncated last period and the restart at the boundary. The slow brownout period is longer than a window, so the second brownout window must show its first processor pulse 400 cycles in, which proves that the slow counter runs across tick boundaries while the fast counters restart.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;

  localparam int unsigned SHIFT_W = 3;

  typedef enum logic [1:0] {
    RATIO_DIV4 = 2'b00,
    RATIO_DIV3 = 2'b01,
    RATIO_DIV2 = 2'b10,
    RATIO_RSVD = 2'b11
  } ratio_e;

  typedef struct packed {
    ratio_e             ratio;
    logic               ce_fast;
    logic [SHIFT_W-1:0] cpu_shift;
    logic               brown;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{
    ratio:     RATIO_DIV4,
    ce_fast:   1'b0,
    cpu_shift: '0,
    brown:     1'b0
  };

  // Divisor D applied to the reference for the scaled master rate.
  function automatic logic [2:0] ratio_to_div(input ratio_e r);
    case (r)
      RATIO_DIV2: ratio_to_div = 3'd2;
      RATIO_DIV3: ratio_to_div = 3'd3;
      default:    ratio_to_div = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/clk_en_phase.sv
module clk_en_phase #(
  parameter int unsigned TICK_DIV = 2400,
  localparam int unsigned CNT_W   = $clog2(TICK_DIV)
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic wrap_o,
  output logic zero_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign wrap_o = (phase_q == LAST);
  assign zero_o = (phase_q == '0);

  // R6: the window count never leaves its range and restarts after the last cycle
  assert_phase_range_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    phase_q <= LAST);
  assert_phase_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> zero_o);

endmodule

// File: rtl/clk_en_cfg.sv
module clk_en_cfg
  import clk_en_pkg::*;
#(
  parameter int unsigned PER_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wrap_i,
  input  logic               ratio_fast_i,
  input  logic               ratio_mid_i,
  input  logic               ce_fast_i,
  input  logic [SHIFT_W-1:0] cpu_shift_i,
  input  logic               brown_i,
  output logic               brown_o,
  output logic [PER_W-1:0]   mck_last_o,
  output logic [PER_W-1:0]   ce_last_o,
  output logic [PER_W-1:0]   adc_last_o,
  output logic [PER_W-1:0]   cpu_last_o
);

  cfg_t             cfg_q;
  cfg_t             cfg_d;
  logic [PER_W-1:0] base;
  logic [PER_W-1:0] quad;

  always_comb begin
    cfg_d.ratio     = ratio_e'({ratio_fast_i, ratio_mid_i});
    cfg_d.ce_fast   = ce_fast_i;
    cfg_d.cpu_shift = cpu_shift_i;
    cfg_d.brown     = brown_i;
  end

  // Settings are adopted only at the window boundary (R9).
  always_ff @(posedge clk_i) begin
    if (rst_i)       cfg_q <= CFG_RESET;
    else if (wrap_i) cfg_q <= cfg_d;
  end

  always_comb begin
    base       = PER_W'(ratio_to_div(cfg_q.ratio));
    quad       = base << 2;
    mck_last_o = base - 1'b1;
    adc_last_o = quad - 1'b1;
    if (cfg_q.ratio == RATIO_DIV2 && !cfg_q.ce_fast) ce_last_o = (base << 3) - 1'b1;
    else                                              ce_last_o = quad - 1'b1;
    cpu_last_o = (quad << cfg_q.cpu_shift) - 1'b1;
  end

  assign brown_o = cfg_q.brown;

  // R9: settings hold steady except on the cycle that closes a window
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> $stable(cfg_q));

endmodule

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         restart_i,
  input  logic [W-1:0] last_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                        cnt_q <= '0;
    else if (restart_i || cnt_q >= last_i) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R5: the period count stays inside the programmed period
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= last_i);

endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen
  import clk_en_pkg::*;
#(
  parameter int unsigned TICK_DIV = 2400,
  parameter int unsigned SLOW_DIV = 2800
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               ratio_fast_i,
  input  logic               ratio_mid_i,
  input  logic               ce_fast_i,
  input  logic [SHIFT_W-1:0] cpu_div_i,
  input  logic               brownout_i,
  output logic               mck_en_o,
  output logic               ce_en_o,
  output logic               adc_en_o,
  output logic               cpu_en_o,
  output logic               tick_en_o
);

  localparam int unsigned PER_W    = 4 + (1 << SHIFT_W);
  localparam int unsigned SLOW_W   = $clog2(SLOW_DIV);
  localparam int unsigned NUM_FAST = 4;
  localparam int unsigned IDX_MCK  = 0;
  localparam int unsigned IDX_CE   = 1;
  localparam int unsigned IDX_ADC  = 2;
  localparam int unsigned IDX_CPU  = 3;
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);

  logic                wrap;
  logic                at_zero;
  logic                brown;
  logic                brown_q;
  logic                slow_hit;
  logic [NUM_FAST-1:0] hit;
  logic [PER_W-1:0]    last_a [NUM_FAST];

  clk_en_phase #(.TICK_DIV(TICK_DIV)) u_phase (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wrap_o (wrap),
    .zero_o (at_zero)
  );

  clk_en_cfg #(.PER_W(PER_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wrap_i       (wrap),
    .ratio_fast_i (ratio_fast_i),
    .ratio_mid_i  (ratio_mid_i),
    .ce_fast_i    (ce_fast_i),
    .cpu_shift_i  (cpu_div_i),
    .brown_i      (brownout_i),
    .brown_o      (brown),
    .mck_last_o   (last_a[IDX_MCK]),
    .ce_last_o    (last_a[IDX_CE]),
    .adc_last_o   (last_a[IDX_ADC]),
    .cpu_last_o   (last_a[IDX_CPU])
  );

  // All fast dividers restart on the same edge, so their pulses line up.
  for (genvar g = 0; g < NUM_FAST; g++) begin : g_fast
    clk_en_div #(.W(PER_W)) u_div (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (wrap),
      .last_i    (last_a[g]),
      .zero_o    (hit[g])
    );
  end

  // Slow brownout rate: held at zero until brownout begins, then free-running.
  clk_en_div #(.W(SLOW_W)) u_slow (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (!brown),
    .last_i    (SLOW_LAST),
    .zero_o    (slow_hit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mck_en_o  <= 1'b0;
      ce_en_o   <= 1'b0;
      adc_en_o  <= 1'b0;
      cpu_en_o  <= 1'b0;
      tick_en_o <= 1'b0;
      brown_q   <= 1'b0;
    end else begin
      tick_en_o <= at_zero;
      brown_q   <= brown;
      if (brown) begin
        mck_en_o <= 1'b0;
        ce_en_o  <= 1'b0;
        adc_en_o <= slow_hit;
        cpu_en_o <= slow_hit;
      end else begin
        mck_en_o <= hit[IDX_MCK];
        ce_en_o  <= hit[IDX_CE];
        adc_en_o <= hit[IDX_ADC];
        cpu_en_o <= hit[IDX_CPU];
      end
    end
  end

  // R7: every fast strobe coincides with the tick outside brownout
  assert_aligned_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_en_o && !brown_q) |-> (mck_en_o && ce_en_o && adc_en_o && cpu_en_o));
  // R10: fast strobes silent during brownout
  assert_brown_quiet_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    brown_q |-> (!mck_en_o && !ce_en_o));
  // R8: single-cycle strobes
  assert_tick_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_en_o |=> !tick_en_o);
  assert_ce_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ce_en_o |=> !ce_en_o);
  assert_adc_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    adc_en_o |=> !adc_en_o);
  assert_cpu_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    cpu_en_o |=> !cpu_en_o);

endmodule

// File: tb/clk_en_gen_tb.sv
`timescale 1ns/1ps
module clk_en_gen_tb_top;

  localparam int TICK = 2400;
  localparam int SLOW = 2800;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, rf, rm, cf, bo;
  logic [2:0] sh;
  logic       mck, ce, adc, cpu, tick;

  clk_en_gen dut_i (
    .clk_i(clk), .rst_i(rst), .ratio_fast_i(rf), .ratio_mid_i(rm),
    .ce_fast_i(cf), .cpu_div_i(sh), .brownout_i(bo),
    .mck_en_o(mck), .ce_en_o(ce), .adc_en_o(adc), .cpu_en_o(cpu), .tick_en_o(tick)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int c_mck, c_ce, c_adc, c_cpu, c_tick, first_cpu, dbl;
  bit aligned;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int div_of(input bit f, input bit m);
    if (f && !m) return 2;
    if (!f && m) return 3;
    return 4;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic wait_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  // Counts one window starting at a negedge where the tick is high.
  task automatic measure(input int chg_at, input bit nf, input bit nm,
                         input bit ncf, input bit nb, input logic [2:0] nsh);
    bit p_ce, p_adc, p_cpu;
    p_ce = 1'b0; p_adc = 1'b0; p_cpu = 1'b0;
    c_mck = 0; c_ce = 0; c_adc = 0; c_cpu = 0; c_tick = 0; first_cpu = -1; dbl = 0;
    aligned = tick && mck && ce && adc && cpu;
    for (int i = 0; i < TICK; i++) begin
      if (i == chg_at) begin rf = nf; rm = nm; cf = ncf; bo = nb; sh = nsh; end
      c_mck += int'(mck); c_ce += int'(ce); c_adc += int'(adc);
      c_cpu += int'(cpu); c_tick += int'(tick);
      if (cpu && first_cpu < 0) first_cpu = i;
      if ((ce && p_ce) || (adc && p_adc) || (cpu && p_cpu)) dbl++;
      p_ce = ce; p_adc = adc; p_cpu = cpu;
      @(negedge clk);
    end
  endtask

  task automatic check_window(input string req, input int e_mck, input int e_ce,
                              input int e_adc, input int e_cpu, input bit want_align);
    chk(req, "mck pulses", c_mck, e_mck);
    chk(req, "ce pulses", c_ce, e_ce);
    chk(req, "adc pulses", c_adc, e_adc);
    chk(req, "cpu pulses", c_cpu, e_cpu);
    chk("R6", "ticks in window", c_tick, 1);
    chk("R6", "tick at window end", int'(tick), 1);
    chk("R8", "double-width pulses", dbl, 0);
    if (want_align) chk("R7", "aligned at tick", int'(aligned), 1);
  endtask

  task automatic expect_mode(input string req, input bit f, input bit m,
                             input bit c, input logic [2:0] s);
    int d;
    d = div_of(f, m);
    check_window(req, ceil_div(TICK, d),
                 ceil_div(TICK, (d == 2 && !c) ? 8 * d : 4 * d),
                 ceil_div(TICK, 4 * d),
                 ceil_div(TICK, (4 * d) << s), 1'b1);
  endtask

  task automatic run_mode(input string req, input bit f, input bit m,
                          input bit c, input logic [2:0] s);
    rf = f; rm = m; cf = c; sh = s; bo = 1'b0;
    wait_tick();
    measure(-1, f, m, c, 1'b0, s);
    expect_mode(req, f, m, c, s);
  endtask

  task automatic test_reset();
    rf = 1'b1; rm = 1'b0; cf = 1'b0; sh = 3'd0; bo = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "outputs in reset", int'({mck, ce, adc, cpu, tick}), 0);
    rst = 1'b0;
    wait_tick();
    measure(-1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    expect_mode("R1", 1'b0, 1'b0, 1'b0, 3'd0);      // default divide-by-4
    measure(-1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    expect_mode("R9", 1'b1, 1'b0, 1'b0, 3'd0);      // inputs adopted at boundary
  endtask

  task automatic test_ratio_codes();
    run_mode("R2", 1'b1, 1'b0, 1'b1, 3'd0);
    run_mode("R2", 1'b0, 1'b1, 1'b0, 3'd0);
    run_mode("R4", 1'b0, 1'b0, 1'b0, 3'd0);
    run_mode("R2", 1'b1, 1'b1, 1'b0, 3'd0);         // reserved code acts as /4
  endtask

  task automatic test_ce_select();
    run_mode("R3", 1'b1, 1'b0, 1'b0, 3'd0);         // /2 slow: period 16
    run_mode("R3", 1'b0, 1'b1, 1'b1, 3'd0);         // bit ignored in /3
    run_mode("R3", 1'b0, 1'b0, 1'b1, 3'd0);         // bit ignored in /4
  endtask

  task automatic test_cpu_shift();
    run_mode("R5", 1'b1, 1'b0, 1'b1, 3'd3);         // period 64 -> 38
    run_mode("R5", 1'b0, 1'b0, 1'b0, 3'd7);         // period 2048 -> 2
    run_mode("R5", 1'b0, 1'b1, 1'b0, 3'd1);         // period 24 -> 100
  endtask

  task automatic test_brownout();
    run_mode("R9", 1'b0, 1'b1, 1'b0, 3'd0);
    measure(1000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5);    // brownout requested mid-window
    expect_mode("R9", 1'b0, 1'b1, 1'b0, 3'd0);
    measure(-1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5);
    check_window("R10", 0, 0, 1, 1, 1'b0);
    chk("R10", "first cpu offset", first_cpu, 0);
    measure(-1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5);
    check_window("R10", 0, 0, 1, 1, 1'b0);
    chk("R10", "slow period carry-over", first_cpu, SLOW - TICK);
    run_mode("R10", 1'b1, 1'b0, 1'b1, 3'd2);        // exit: period 32 -> 75
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog: actual %0d expected %0d cycles", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_ratio_codes();
    test_ce_select();
    test_cpu_shift();
    test_brownout();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule